// File: doc/BRIEF.md
# Sticky Error History Bank with Timed Expiry

This block collects sixteen single-cycle event or error strobes into a bank of sticky flags. A strobe raises its flag, and the flag then holds for a host-chosen number of seconds before it drops by itself. Each flag keeps its own countdown. The countdown is measured in ticks of a one-second strobe, which an internal prescaler derives from the system clock. Because every strobe of the same source reloads its flag's countdown, a flag stays up as long as its source keeps firing. It goes down a fixed time after the last occurrence.

A small register port controls the bank. The host uses it to set the hold time, read the flags, raise flags by hand to test their expiry, and wipe the whole bank at once. One hold-time code disables expiry altogether. The hold time is sampled into a flag's countdown whenever that flag is loaded. If the host changes the hold time, countdowns that are already running are not disturbed.

Top module: `err_hist_bank`

## Requirements
- R1: After reset the hold-time register reads 8 and every history flag reads 0.
- R2: Address 0 holds the hold time in seconds. A read returns it in bits 7-0 with bits 15-8 zero, and bits 15-8 of a write are discarded.
- R3: An event input that is high at a clock edge sets its history flag at that edge and loads the flag's countdown with the current hold time.
- R4: Writing to address 1 sets every history flag whose data bit is 1. Flags whose data bit is 0 keep their state. A read of address 1 returns the flags in bits 15-0.
- R5: A second tick occurs once every CLK_HZ clock cycles, the first in the CLK_HZ-th cycle after reset. A flag loaded with a hold time P in 1..254 clears on the P-th tick after its last load.
- R6: A flag loaded with hold time 255 never clears by itself.
- R7: A flag loaded with hold time 0 clears on the first tick after its load.
- R8: A new event on a flag that is already set reloads its countdown, which delays the expiry.
- R9: A write to address 2 with bit 0 set clears every history flag in the next cycle.
- R10: When an event or a host set meets a clear in the same cycle, that flag ends up set with a fresh countdown.
- R11: A change of the hold time applies only to later loads. Flags already counting keep the time they were loaded with.
- R12: Flags count independently. The load or expiry of one flag leaves the others unchanged.
- R13: Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_EVT | Event strobes, one per history flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address, for both reads and writes |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on reg_addr_i |

## Verification
The bench builds the block with CLK_HZ set to 10, so one "second" lasts ten clock cycles. With that setting, hold times of several seconds, reloads in the middle of a countdown, and long stretches at the never-expire code all run out within a few hundred cycles. N_EVT stays at 16, so the full register width and every per-flag countdown are exercised. The event strobes are placed at various phases of the tick, which checks expiry at both ends of the one-tick uncertainty window.

// File: rtl/err_hist_pkg.sv
package err_hist_pkg;

  localparam int PER_W  = 8;
  localparam int DATA_W = 16;
  localparam logic [PER_W-1:0] PER_FOREVER = '1;
  localparam logic [PER_W-1:0] PER_RESET   = 8'd8;

  typedef enum logic [1:0] {
    ADR_PERSIST = 2'd0,
    ADR_HIST    = 2'd1,
    ADR_WIPE    = 2'd2,
    ADR_SPARE   = 2'd3
  } reg_adr_e;

  // True when a running countdown ends on this tick.
  function automatic logic cd_ends(input logic [PER_W-1:0] c);
    return (c != PER_FOREVER) && (c <= PER_W'(1));
  endfunction

  // Countdown value after one tick.
  function automatic logic [PER_W-1:0] cd_step(input logic [PER_W-1:0] c);
    if (c == PER_FOREVER) return c;
    if (c == '0)          return c;
    return c - PER_W'(1);
  endfunction

endpackage

// File: rtl/sec_strobe.sv
module sec_strobe #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DIV_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HZ - 1);

  logic [DIV_W-1:0] div_q;
  logic             wrap_w;

  assign wrap_w = (div_q == DIV_LAST);
  assign tick_o = wrap_w;

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (wrap_w) div_q <= '0;
    else             div_q <= div_q + DIV_W'(1);
  end

  // R5: after a tick the divider starts a fresh second
  a_r5_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (div_q == '0));

endmodule

// File: rtl/hist_regs.sv
module hist_regs
  import err_hist_pkg::*;
#(
  parameter int N_EVT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_EVT-1:0]  hist_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PER_W-1:0]  persist_o,
  output logic [N_EVT-1:0]  host_set_o,
  output logic              wipe_o
);
  logic [PER_W-1:0] persist_q;
  logic             wr_persist_w;
  logic             wr_hist_w;

  assign wr_persist_w = wr_i && (reg_adr_e'(addr_i) == ADR_PERSIST);
  assign wr_hist_w    = wr_i && (reg_adr_e'(addr_i) == ADR_HIST);
  assign wipe_o       = wr_i && (reg_adr_e'(addr_i) == ADR_WIPE) && wdata_i[0];
  assign host_set_o   = wr_hist_w ? wdata_i[N_EVT-1:0] : '0;
  assign persist_o    = persist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            persist_q <= PER_RESET;
    else if (wr_persist_w) persist_q <= wdata_i[PER_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_adr_e'(addr_i))
      ADR_PERSIST: rdata_o[PER_W-1:0] = persist_q;
      ADR_HIST:    rdata_o[N_EVT-1:0] = hist_i;
      default:     rdata_o = '0;
    endcase
  end

  // R2: the hold time moves only on a write to its address
  a_r2_persist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_persist_w |=> $stable(persist_q));
  // R2: the upper read byte of the hold-time register is always zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_adr_e'(addr_i) == ADR_PERSIST) |-> (rdata_o[DATA_W-1:PER_W] == '0));

endmodule

// File: rtl/hist_cell.sv
module hist_cell
  import err_hist_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             set_i,
  input  logic             wipe_i,
  input  logic [PER_W-1:0] persist_i,
  output logic             flag_o
);
  logic             flag_q;
  logic [PER_W-1:0] cd_q;
  logic             expire_w;
  logic             step_w;

  assign expire_w = tick_i && flag_q && cd_ends(cd_q);
  assign step_w   = tick_i && flag_q;
  assign flag_o   = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cd_q   <= '0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      cd_q   <= persist_i;
    end else if (wipe_i || expire_w) begin
      flag_q <= 1'b0;
      cd_q   <= '0;
    end else if (step_w) begin
      cd_q   <= cd_step(cd_q);
    end
  end

  // R3: a set raises the flag and loads the current hold time
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (flag_q && cd_q == $past(persist_i)));
  // R5: a countdown at one ends on the tick
  a_r5_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && tick_i && cd_q == PER_W'(1) && !set_i) |=> !flag_q);
  // R6: the never-expire code holds the flag until a wipe or reload
  a_r6_forever: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && cd_q == PER_FOREVER && !wipe_i && !set_i) |=> (flag_q && cd_q == PER_FOREVER));
  // R9: a wipe without a set drops the flag
  a_r9_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_i && !set_i) |=> !flag_q);
  // R5: without a tick, a set or a wipe, the flag keeps its state
  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !set_i && !wipe_i) |=> ($stable(flag_q) && $stable(cd_q)));

endmodule

// File: rtl/err_hist_bank.sv
module err_hist_bank
  import err_hist_pkg::*;
#(
  parameter int N_EVT  = 16,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic             sec_tick_w;
  logic [PER_W-1:0] persist_w;
  logic [N_EVT-1:0] host_set_w;
  logic [N_EVT-1:0] set_w;
  logic [N_EVT-1:0] flags_w;
  logic             wipe_w;

  initial begin
    if (N_EVT < 1 || N_EVT > DATA_W) $error("N_EVT must be 1..16");
  end

  sec_strobe #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (sec_tick_w)
  );

  hist_regs #(.N_EVT(N_EVT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .hist_i     (flags_w),
    .rdata_o    (reg_rdata_o),
    .persist_o  (persist_w),
    .host_set_o (host_set_w),
    .wipe_o     (wipe_w)
  );

  assign set_w = evt_i | host_set_w;

  for (genvar g = 0; g < N_EVT; g++) begin : g_cell
    hist_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (sec_tick_w),
      .set_i     (set_w[g]),
      .wipe_i    (wipe_w),
      .persist_i (persist_w),
      .flag_o    (flags_w[g])
    );
  end

  // R10: a set that meets a wipe leaves the flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_w && set_w != '0) |=> ((flags_w & $past(set_w)) == $past(set_w)));
  // R12: with no tick, no wipe and no set, no flag moves
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick_w && !wipe_w && set_w == '0) |=> $stable(flags_w));

endmodule

// File: tb/sim_err_hist_bank.sv
`timescale 1ns/1ps
module sim_err_hist_bank;
  localparam int N  = 16;
  localparam int HZ = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  err_hist_bank #(.N_EVT(N), .CLK_HZ(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // Expected state, from the requirements
  int          m_sec;
  logic [7:0]  m_per;
  logic [N-1:0] m_flag;
  logic [7:0]  m_cd [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec  <= 0;
      m_per  <= 8'd8;
      m_flag <= '0;
      for (int i = 0; i < N; i++) m_cd[i] <= 8'd0;
    end else begin
      logic tk, wipe, s;
      tk   = (m_sec == HZ - 1);
      wipe = wr && addr == 2'd2 && wdata[0];
      m_sec <= tk ? 0 : m_sec + 1;
      if (wr && addr == 2'd0) m_per <= wdata[7:0];
      for (int i = 0; i < N; i++) begin
        s = evt[i] || (wr && addr == 2'd1 && wdata[i]);
        if (s) begin
          m_flag[i] <= 1'b1; m_cd[i] <= m_per;
        end else if (wipe) begin
          m_flag[i] <= 1'b0; m_cd[i] <= 8'd0;
        end else if (tk && m_flag[i] && m_cd[i] != 8'hFF) begin
          if (m_cd[i] <= 8'd1) begin m_flag[i] <= 1'b0; m_cd[i] <= 8'd0; end
          else m_cd[i] <= m_cd[i] - 8'd1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0; addr = 2'd1;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  // Compare the flags against the model for n cycles
  task automatic track(input int n, input string tag);
    logic [15:0] d;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rd(2'd1, d);
      chk(d == 16'(m_flag), tag, d, 16'(m_flag));
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(2'd0, d); chk(d == 16'd8, "R1 hold time", d, 16'd8);
    rd(2'd1, d); chk(d == 16'd0, "R1 flags", d, 16'd0);
    rd(2'd3, d); chk(d == 16'd0, "R13 spare", d, 16'd0);
  endtask

  task automatic t_persist_rw;
    logic [15:0] d;
    wreg(2'd0, 16'hAB05);
    rd(2'd0, d); chk(d == 16'h0005, "R2 upper dropped", d, 16'h0005);
    wreg(2'd0, 16'h00FE);
    rd(2'd0, d); chk(d == 16'h00FE, "R2 full byte", d, 16'h00FE);
  endtask

  task automatic t_event_expiry;
    logic [15:0] d;
    wreg(2'd0, 16'd3);
    pulse(16'h0008);
    rd(2'd1, d); chk(d == 16'h0008, "R3 event sets", d, 16'h0008);
    tick_cycles(2*HZ - 1);
    rd(2'd1, d); chk(d == 16'h0008, "R5 still held", d, 16'h0008);
    tick_cycles(HZ + 1);
    rd(2'd1, d); chk(d == 16'h0000, "R5 expired", d, 16'h0000);
    pulse(16'h0100); tick_cycles(3);
    track(4*HZ, "R5 phase tracked");
  endtask

  task automatic t_host_set;
    logic [15:0] d;
    wreg(2'd0, 16'd5);
    pulse(16'h0001);
    wreg(2'd1, 16'h00F0);
    rd(2'd1, d); chk(d == 16'h00F1, "R4 host set", d, 16'h00F1);
    wreg(2'd1, 16'h0000);
    rd(2'd1, d); chk(d == 16'h00F1, "R4 zero bits no effect", d, 16'h00F1);
    track(6*HZ, "R12 independent");
    rd(2'd1, d); chk(d == 16'h0000, "R4 host flags expire", d, 16'h0000);
  endtask

  task automatic t_forever;
    logic [15:0] d;
    wreg(2'd0, 16'h00FF);
    pulse(16'h8000);
    tick_cycles(40*HZ);
    rd(2'd1, d); chk(d == 16'h8000, "R6 never expires", d, 16'h8000);
    wreg(2'd2, 16'h0001);
    rd(2'd1, d); chk(d == 16'h0000, "R9 wipe", d, 16'h0000);
  endtask

  task automatic t_zero;
    logic [15:0] d;
    wreg(2'd0, 16'd0);
    pulse(16'h0040);
    rd(2'd1, d); chk(d == 16'h0040, "R7 set with zero", d, 16'h0040);
    tick_cycles(HZ);
    rd(2'd1, d); chk(d == 16'h0000, "R7 first tick clears", d, 16'h0000);
  endtask

  task automatic t_reload;
    logic [15:0] d;
    wreg(2'd0, 16'd2);
    pulse(16'h0200);
    tick_cycles(HZ);
    pulse(16'h0200);
    tick_cycles(HZ - 1);
    rd(2'd1, d); chk(d == 16'h0200, "R8 reload delays", d, 16'h0200);
    track(2*HZ + 2, "R8 reload tracked");
    rd(2'd1, d); chk(d == 16'h0000, "R8 eventual expiry", d, 16'h0000);
  endtask

  task automatic t_wipe_race;
    logic [15:0] d;
    wreg(2'd0, 16'd4);
    wreg(2'd1, 16'h0003);
    @(negedge clk); wr = 1'b1; addr = 2'd2; wdata = 16'h0001; evt = 16'h0002;
    @(negedge clk); wr = 1'b0; wdata = '0; evt = '0; addr = 2'd1;
    rd(2'd1, d); chk(d == 16'h0002, "R10 event beats wipe", d, 16'h0002);
    wreg(2'd2, 16'h0002);
    rd(2'd1, d); chk(d == 16'h0002, "R9 bit0 clear ignores", d, 16'h0002);
    track(5*HZ, "R10 fresh countdown");
  endtask

  task automatic t_change;
    logic [15:0] d;
    wreg(2'd0, 16'd6);
    pulse(16'h0010);
    wreg(2'd0, 16'd1);
    pulse(16'h0020);
    tick_cycles(2*HZ + 1);
    rd(2'd1, d); chk(d == 16'h0010, "R11 running count kept", d, 16'h0010);
    track(5*HZ, "R11 tracked");
    rd(2'd1, d); chk(d == 16'h0000, "R11 old time expires", d, 16'h0000);
  endtask

  initial begin
    tick_cycles(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_persist_rw();
    t_event_expiry();
    t_host_set();
    t_forever();
    t_zero();
    t_reload();
    t_wipe_race();
    t_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule